// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

A memory-mapped bank of general-purpose pins, 36 by default and up to 64. Each pin can be set as an input or an output. When it is an output, it drives a value held in a register. Every pin's input is passed through a two-stage synchroniser and can be read back. A per-pin edge detector watches the synchronised value. A polarity bit selects whether it reacts to the rising or the falling transition. A detected edge sets a sticky status bit that software clears by writing a one.

The bank has two combined outputs. The interrupt line is raised while any pending status bit is also enabled. The wake line is raised while any pending status bit also has its wake-up enable set. The register port is a plain 32-bit write/read bus with byte addresses, and reads are combinational. Each register group is two words wide. Pins 0 to 31 are in the low word. Pins 32 and up are in the word 4 bytes higher, at bit position (pin − 32). Address bit 6 selects the interrupt region (0x40 and up) over the pin region.

The block has no multi-state controller. Every register is a flat flop array with its own next-state rule.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every register is zero, so every pin is an input: pin_oe is 0, pin_out is 0, irq is 0, wake is 0, and a status read returns 0.
- R2: The direction word at 0x00 drives pin_oe, where a bit of 1 makes the pin an output. The output value word at 0x18 drives pin_out.
- R3: Pin n is at bit (n mod 32) of the group's base word when n < 32, and of the word at base+4 otherwise. Bits for pins beyond NUM_PINS read as 0, and writes to them are dropped.
- R4: The input value word at 0x10 (pins 32+ at 0x14) returns the pin level after two synchronising flops. A change applied before a clock edge is readable after the second rising edge.
- R5: The interrupt region is laid out as follows. The enable word is at 0x40, the polarity word at 0x48, the status word at 0x50 and the wake-up enable word at 0x58, each with its upper word 4 bytes higher.
- R6: A polarity bit of 0 latches a rising edge and a polarity bit of 1 latches a falling edge. The opposite transition is ignored. Status updates on the third rising clock edge after the input change.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A status write never sets a bit.
- R8: When a new edge and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R9: irq is 1 exactly when some pin has both its status bit and its enable bit set.
- R10: wake is 1 exactly when some pin has both its status bit and its wake-up enable bit set.
- R11: Reads return 0 from unmapped offsets (such as 0x08, 0x20 and 0x60) and from any address whose low two bits are not zero. Writes to such addresses change nothing.
- R12: A status bit stays set until it is cleared, and it does not block other pins from latching. Clearing one bit leaves the other pending bits set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| pin_out | output | NUM_PINS | Per-pin output value |
| irq | output | 1 | Combined enabled interrupt |
| wake | output | 1 | Combined wake-up request |

## Verification
A write-one-to-clear of a status bit can land on the same clock edge as a fresh edge on that pin. The bench provokes this directly. It raises a pin and times the clear so that the write takes effect on the third clock edge after the change, which is the edge where the detector sets the bit. The bit is judged correct if it reads back as 1 afterwards. The random phase also produces many more such collisions across both status words, and every status read is compared against a reference model in which a set beats a clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 7;
    localparam int MAX_PINS = 64;

    // register group selected by address bits [6:3]; bit [2] picks the upper word
    typedef enum logic [3:0] {
        GRP_DIR   = 4'h0,
        GRP_INVAL = 4'h2,
        GRP_OUTV  = 4'h3,
        GRP_IEN   = 4'h8,
        GRP_IPOL  = 4'h9,
        GRP_ISTAT = 4'hA,
        GRP_IWAKE = 4'hB
    } reg_grp_e;

    function automatic logic [MAX_PINS-1:0] pin_mask(input int n);
        logic [MAX_PINS-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_PINS; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [MAX_PINS-1:0] merge_word(
        input logic [MAX_PINS-1:0] cur,
        input logic                upper,
        input logic [BUS_W-1:0]    d
    );
        return upper ? {d, cur[BUS_W-1:0]} : {cur[MAX_PINS-1:BUS_W], d};
    endfunction

    function automatic logic [MAX_PINS-1:0] word_bits(
        input logic             upper,
        input logic [BUS_W-1:0] d
    );
        return upper ? {d, {BUS_W{1'b0}}} : {{BUS_W{1'b0}}, d};
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] sync_val,
    output logic [NUM_PINS-1:0] rise,
    output logic [NUM_PINS-1:0] fall
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign sync_val = sync_q;
    assign rise     = sync_q & ~prev_q;
    assign fall     = ~sync_q & prev_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_pol,
    input  logic                wr_stat,
    input  logic                wr_wake,
    input  logic                upper,
    input  logic [BUS_W-1:0]    wdata,
    input  logic [MAX_PINS-1:0] rise,
    input  logic [MAX_PINS-1:0] fall,
    output logic [MAX_PINS-1:0] en_q,
    output logic [MAX_PINS-1:0] pol_q,
    output logic [MAX_PINS-1:0] stat_q,
    output logic [MAX_PINS-1:0] wk_q,
    output logic [MAX_PINS-1:0] hit,
    output logic                irq,
    output logic                wake
);

    localparam logic [MAX_PINS-1:0] PMASK = pin_mask(NUM_PINS);

    logic [MAX_PINS-1:0] clr;
    logic [MAX_PINS-1:0] stat_d;

    always_comb begin
        hit    = ((rise & ~pol_q) | (fall & pol_q)) & PMASK;
        clr    = wr_stat ? word_bits(upper, wdata) : '0;
        stat_d = (stat_q & ~clr) | hit;   // a fresh edge beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            stat_q <= '0;
            wk_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (wr_en)   en_q  <= merge_word(en_q,  upper, wdata) & PMASK;
            if (wr_pol)  pol_q <= merge_word(pol_q, upper, wdata) & PMASK;
            if (wr_wake) wk_q  <= merge_word(wk_q,  upper, wdata) & PMASK;
        end
    end

    assign irq  = |(stat_q & en_q);
    assign wake = |(stat_q & wk_q);

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic                irq,
    output logic                wake
);

    localparam logic [MAX_PINS-1:0] PMASK = pin_mask(NUM_PINS);

    logic        aligned;
    logic        upper;
    reg_grp_e    grp;
    logic        wr_dir, wr_outv, wr_en, wr_pol, wr_stat, wr_wake;

    logic [MAX_PINS-1:0] dir_q, outv_q;
    logic [NUM_PINS-1:0] sync_val, rise_n, fall_n;
    logic [MAX_PINS-1:0] in_vec, rise_vec, fall_vec;
    logic [MAX_PINS-1:0] en_vec, pol_vec, stat_vec, wk_vec, hit_vec;
    logic [MAX_PINS-1:0] sel_vec;

    // address decode
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign upper   = bus_addr[2];
    assign grp     = reg_grp_e'(bus_addr[6:3]);

    assign wr_dir  = bus_we && aligned && (grp == GRP_DIR);
    assign wr_outv = bus_we && aligned && (grp == GRP_OUTV);
    assign wr_en   = bus_we && aligned && (grp == GRP_IEN);
    assign wr_pol  = bus_we && aligned && (grp == GRP_IPOL);
    assign wr_stat = bus_we && aligned && (grp == GRP_ISTAT);
    assign wr_wake = bus_we && aligned && (grp == GRP_IWAKE);

    // pin-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            outv_q <= '0;
        end else begin
            if (wr_dir)  dir_q  <= merge_word(dir_q,  upper, bus_wdata) & PMASK;
            if (wr_outv) outv_q <= merge_word(outv_q, upper, bus_wdata) & PMASK;
        end
    end

    assign pin_oe  = dir_q[NUM_PINS-1:0];
    assign pin_out = outv_q[NUM_PINS-1:0];

    gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .sync_val (sync_val),
        .rise     (rise_n),
        .fall     (fall_n)
    );

    assign in_vec   = MAX_PINS'(sync_val);
    assign rise_vec = MAX_PINS'(rise_n);
    assign fall_vec = MAX_PINS'(fall_n);

    gpio_irq_unit #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_pol  (wr_pol),
        .wr_stat (wr_stat),
        .wr_wake (wr_wake),
        .upper   (upper),
        .wdata   (bus_wdata),
        .rise    (rise_vec),
        .fall    (fall_vec),
        .en_q    (en_vec),
        .pol_q   (pol_vec),
        .stat_q  (stat_vec),
        .wk_q    (wk_vec),
        .hit     (hit_vec),
        .irq     (irq),
        .wake    (wake)
    );

    // read path
    always_comb begin
        sel_vec = '0;
        if (aligned) begin
            case (grp)
                GRP_DIR:   sel_vec = dir_q;
                GRP_INVAL: sel_vec = in_vec;
                GRP_OUTV:  sel_vec = outv_q;
                GRP_IEN:   sel_vec = en_vec;
                GRP_IPOL:  sel_vec = pol_vec;
                GRP_ISTAT: sel_vec = stat_vec;
                GRP_IWAKE: sel_vec = wk_vec;
                default:   sel_vec = '0;
            endcase
        end
        bus_rdata = upper ? sel_vec[MAX_PINS-1:BUS_W] : sel_vec[BUS_W-1:0];
    end

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [MAX_PINS-1:0] stat,
    input logic [MAX_PINS-1:0] en,
    input logic [MAX_PINS-1:0] wk,
    input logic [MAX_PINS-1:0] hit,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic                wake
);

    logic stat_lo_wr;
    logic stat_any_wr;
    assign stat_any_wr = bus_we && (bus_addr[1:0] == 2'b00) && (bus_addr[6:3] == 4'hA);
    assign stat_lo_wr  = stat_any_wr && !bus_addr[2];

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && stat == '0)); // R1

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_any_wr |=> ((stat & $past(stat)) == $past(stat))); // R12

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_lo_wr && hit == '0) |=> ((stat[BUS_W-1:0] & $past(bus_wdata)) == '0)); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat & $past(hit)) == $past(hit))); // R8

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq); // R9

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (wk == '0) |-> !wake); // R10

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat      (stat_vec),
    .en        (en_vec),
    .wk        (wk_vec),
    .hit       (hit_vec),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .wake      (wake)
);

// File: tb/gpio_edge_bank_test.sv
`timescale 1ns/10ps
module gpio_edge_bank_test;

    localparam int N = 36;
    localparam logic [63:0] MASK = 64'h0000_000F_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_oe, pin_out;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gpio_edge_bank #(.NUM_PINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq), .wake(wake)
    );

    // reference model built from the requirements
    logic [63:0] m_dir, m_out, m_en, m_pol, m_stat, m_wk, h1, h2, h3;

    function automatic logic [63:0] put(logic [63:0] cur, logic up, logic [31:0] d);
        return (up ? {d, cur[31:0]} : {cur[63:32], d}) & MASK;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dir <= '0; m_out <= '0; m_en <= '0; m_pol <= '0;
            m_stat <= '0; m_wk <= '0; h1 <= '0; h2 <= '0; h3 <= '0;
        end else begin
            logic [63:0] edges, clr;
            h1 <= 64'(pin_in); h2 <= h1; h3 <= h2;
            edges = ((h2 & ~h3 & ~m_pol) | (~h2 & h3 & m_pol)) & MASK;
            clr = '0;
            if (bus_we && bus_addr[1:0] == 2'b00) begin
                case (bus_addr[6:3])
                    4'h0: m_dir <= put(m_dir, bus_addr[2], bus_wdata);
                    4'h3: m_out <= put(m_out, bus_addr[2], bus_wdata);
                    4'h8: m_en  <= put(m_en,  bus_addr[2], bus_wdata);
                    4'h9: m_pol <= put(m_pol, bus_addr[2], bus_wdata);
                    4'hA: clr = bus_addr[2] ? {bus_wdata, 32'd0} : {32'd0, bus_wdata};
                    4'hB: m_wk  <= put(m_wk,  bus_addr[2], bus_wdata);
                    default: ;
                endcase
            end
            m_stat <= (m_stat & ~clr) | edges;
        end
    end

    function automatic logic [31:0] exp_rd(logic [6:0] a);
        logic [63:0] v;
        v = '0;
        if (a[1:0] == 2'b00) begin
            case (a[6:3])
                4'h0: v = m_dir;
                4'h2: v = h2 & MASK;
                4'h3: v = m_out;
                4'h8: v = m_en;
                4'h9: v = m_pol;
                4'hA: v = m_stat;
                4'hB: v = m_wk;
                default: v = '0;
            endcase
        end
        return a[2] ? v[63:32] : v[31:0];
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    function automatic logic [6:0] rand_wr_addr();
        case ($urandom % 12)
            0: return 7'h00;  1: return 7'h04;  2: return 7'h18;  3: return 7'h1C;
            4: return 7'h40;  5: return 7'h44;  6: return 7'h48;  7: return 7'h4C;
            8: return 7'h50;  9: return 7'h54;  10: return 7'h58; default: return 7'h5C;
        endcase
    endfunction

    function automatic logic [6:0] rand_rd_addr();
        case ($urandom % 8)
            0: return 7'h10;
            1: return 7'h14;
            2: return 7'h20;
            3: return 7'h61;
            default: return rand_wr_addr();
        endcase
    endfunction

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int seed;
        seed = $urandom(32'd20240611);
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 pin_oe", 64'(pin_oe), 0);
        chk("R1 pin_out", 64'(pin_out), 0);
        chk("R1 irq/wake", {62'd0, irq, wake}, 0);
        rd(7'h50, r); chk("R1 status", 64'(r), 0);

        // R2 / R3 direction and output value, upper word
        wr(7'h00, 32'hA5A5_0001);
        chk("R2 pin_oe low", 64'(pin_oe[31:0]), 64'hA5A5_0001);
        wr(7'h04, 32'hFFFF_FFFF);
        chk("R3 pin_oe upper", 64'(pin_oe[35:32]), 64'hF);
        rd(7'h04, r); chk("R3 unused bits", 64'(r), 64'hF);
        wr(7'h1C, 32'h0000_0005);
        chk("R2 pin_out upper", 64'(pin_out[35:32]), 64'h5);

        // R4 synchroniser latency on pin 33
        pin_in[33] = 1'b1;
        step(1); rd(7'h14, r); chk("R4 after one edge", 64'(r[1]), 0);
        step(1); rd(7'h14, r); chk("R4 after two edges", 64'(r[1]), 1);
        step(2);
        wr(7'h54, 32'hFFFF_FFFF);   // drop the edge latched above

        // R6 / R5 falling edge ignored with polarity 0
        wr(7'h44, 32'h2);
        pin_in[33] = 1'b0;
        step(4); rd(7'h54, r); chk("R6 opposite edge ignored", 64'(r), 0);
        wr(7'h4C, 32'h2);           // falling edge for pin 33
        pin_in[33] = 1'b1;
        step(4); rd(7'h54, r); chk("R6 rising ignored when pol=1", 64'(r), 0);
        pin_in[33] = 1'b0;
        step(2); rd(7'h54, r); chk("R6 not yet at edge two", 64'(r), 0);
        step(1); rd(7'h54, r); chk("R6 falling latched at edge three", 64'(r), 2);
        chk("R9 irq with enable", 64'(irq), 1);

        // R10 wake, R9 gating
        wr(7'h5C, 32'h2);
        chk("R10 wake", 64'(wake), 1);
        wr(7'h44, 32'h0);
        chk("R9 irq gated off", 64'(irq), 0);
        chk("R10 wake kept", 64'(wake), 1);

        // R7 write-one-to-clear
        wr(7'h54, 32'h0);
        rd(7'h54, r); chk("R7 zero write keeps", 64'(r), 2);
        wr(7'h54, 32'h2);
        rd(7'h54, r); chk("R7 one write clears", 64'(r), 0);
        chk("R10 wake after clear", 64'(wake), 0);

        // R12 pending bits accumulate
        wr(7'h40, 32'h7);
        pin_in[0] = 1'b1; step(4);
        pin_in[1] = 1'b1; step(4);
        rd(7'h50, r); chk("R12 two pending", 64'(r), 3);
        wr(7'h50, 32'h1);
        rd(7'h50, r); chk("R12 other bit kept", 64'(r), 2);
        chk("R9 irq still pending", 64'(irq), 1);
        wr(7'h50, 32'h2);

        // R8 edge and clear on the same clock edge
        pin_in[2] = 1'b1;
        step(2);
        bus_we = 1'b1; bus_addr = 7'h50; bus_wdata = 32'h4;
        step(1);
        bus_we = 1'b0;
        rd(7'h50, r); chk("R8 set wins", 64'(r), 4);
        wr(7'h50, 32'h4);
        rd(7'h50, r); chk("R8 later clear works", 64'(r), 0);

        // R11 unmapped and misaligned
        rd(7'h08, r); chk("R11 read 0x08", 64'(r), 0);
        rd(7'h20, r); chk("R11 read 0x20", 64'(r), 0);
        rd(7'h60, r); chk("R11 read 0x60", 64'(r), 0);
        rd(7'h01, r); chk("R11 misaligned read", 64'(r), 0);
        wr(7'h01, 32'hFFFF_FFFF);
        wr(7'h20, 32'hFFFF_FFFF);
        rd(7'h00, r); chk("R11 writes ignored", 64'(r), 64'hA5A5_0001);

        // random phase against the model
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R9 irq", 64'(irq), 64'(|(m_stat & m_en)));
            chk("R10 wake", 64'(wake), 64'(|(m_stat & m_wk)));
            chk("R2 pins", {pin_oe[31:0], pin_out[31:0]}, {m_dir[31:0], m_out[31:0]});
            begin
                logic [6:0] a;
                a = rand_rd_addr();
                rd(a, r);
                chk("R3 R5 R7 R8 read", 64'(r), 64'(exp_rd(a)));
            end
            #0.5;
            if ($urandom % 3 == 0) pin_in = pin_in ^ (N'(1) << ($urandom % N));
            bus_we = ($urandom % 3 == 0);
            bus_addr = rand_wr_addr();
            bus_wdata = $urandom;
        end
        @(negedge clk); bus_we = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule